// File: doc/BRIEF.md
# CDR Lock Supervisor

This block is the digital supervisor of a dual-rate clock-and-data-recovery loop. It decides whether the recovery PLL steers to the local 19.44 MHz reference or to the incoming serial data. It reports whether the loop is locked. It also silences the receive data whenever the input signal is not trustworthy. The recovered clock arrives as a digital clock input. A mode pin selects which prescaler divides it down, so that either line rate (622.08 or 155.52 Mbit/s) nominally matches the reference.

A frequency meter counts divided recovered-clock edges over a fixed window of reference cycles. The count is passed to the reference domain through a toggle handshake. There it is compared against the window length with a tolerance of about 500 ppm.

The acquisition controller always starts on the reference. It hands the PLL to the data stream only after a run of consecutive passing windows while the signal is present. It falls back to the reference at once on a failing window or on loss of signal. Loss of signal is raised by a low signal-detect input or by a low force-to-reference input. While it is raised the serial data output is forced low. Because the controller has fallen back, the clock keeps coming from the reference.

Top module: `cdr_lock_supervisor`

## Requirements
- R1: During and directly after reset, `lockOut` and `trackSel` are 0, `losOut` is 1 and `rxDataOut` is 0.
- R2: `losOut` is the OR of a low `sigDetIn` and a low `forceRefN`. Each input passes through a two-flop synchroniser and one output register. A change driven between two reference edges appears on `losOut` after the third following rising edge of `refClk`, and not before.
- R3: While `losOut` is 1, `rxDataOut` is 0. While `losOut` is 0, `rxDataOut` equals `rxDataIn`.
- R4: A measurement window lasts `WIN` reference cycles. It passes when the count of divided recovered-clock edges differs from `WIN` by at most `TOL`. With the defaults, 65,536 and 32 give about 488 ppm.
- R5: The prescaler divides `recClk` by `DIV_FAST` (default 32) when `rateFast` is 1, and by `DIV_SLOW` (default 8) when `rateFast` is 0. A clock at the other rate's frequency therefore fails every window.
- R6: `lockOut` rises only after `LOCK_PASSES` (default 2) consecutive passing windows with `losOut` at 0. In the cycle before the rise, `losOut` was 0.
- R7: A failing window result while locked drives `lockOut` and `trackSel` to 0 on the next reference edge.
- R8: `lockOut` is 0 one reference edge after `losOut` rises.
- R9: A failing window during acquisition clears the run of passes. The next `LOCK_PASSES` windows must all pass before `lockOut` rises.
- R10: `trackSel` (1 = track data, 0 = track reference) is 1 exactly when `lockOut` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Local reference clock (19.44 MHz nominal) |
| recClk | input | 1 | Recovered clock from the PLL |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| rateFast | input | 1 | 1 = 622.08 Mbit/s prescaler, 0 = 155.52 Mbit/s prescaler |
| sigDetIn | input | 1 | Signal detect, active high, asynchronous |
| forceRefN | input | 1 | Force tracking of the reference, active low, asynchronous |
| rxDataIn | input | 1 | Serial receive data |
| rxDataOut | output | 1 | Serial receive data, forced to 0 during loss of signal |
| lockOut | output | 1 | Lock indication |
| trackSel | output | 1 | PLL tracking source: 1 = data, 0 = reference |
| losOut | output | 1 | Loss-of-signal indication |

## Verification
The hardest case is a broken run of passing windows. It needs a pass, then a fail, then more passes, and the results must land on known window boundaries. The bench reaches it by changing the recovered-clock period in the middle of the second window and restoring it just after the third window starts. The third window stays within tolerance, so a controller that did not clear its run would lock one window early.

Frequency boundaries are exercised by choosing clock periods just inside and well outside the tolerance. The window is shortened through parameters so that each case settles in a few hundred reference cycles.

// File: rtl/cdr_sup_pkg.sv
`timescale 1ns/1ps
package cdr_sup_pkg;

  typedef enum logic [0:0] {
    ST_REF  = 1'b0,
    ST_DATA = 1'b1
  } supState_t;

  // datapath -> control
  typedef struct packed {
    logic winDone;
    logic winPass;
    logic los;
  } meterStat_t;

  // control -> datapath
  typedef struct packed {
    logic muteData;
  } ctlStrobe_t;

endpackage

// File: rtl/cdr_sync_bit.sv
`timescale 1ns/1ps
module cdr_sync_bit #(
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shReg <= {STAGES{RESET_VAL}};
    else       shReg <= {shReg[STAGES-2:0], d};
  end

  assign q = shReg[STAGES-1];
endmodule

// File: rtl/cdr_sup_datapath.sv
`timescale 1ns/1ps
module cdr_sup_datapath
  import cdr_sup_pkg::*;
#(
  parameter int WIN         = 65536,
  parameter int TOL         = 32,
  parameter int DIV_FAST    = 32,
  parameter int DIV_SLOW    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       refClk,
  input  logic       recClk,
  input  logic       rstN,
  input  logic       rateFast,
  input  logic       sigDetIn,
  input  logic       forceRefN,
  input  logic       rxDataIn,
  input  ctlStrobe_t ctl,
  output meterStat_t stat,
  output logic       rxDataOut
);
  localparam int CNT_W   = $clog2(WIN) + 3;
  localparam int WT_W    = $clog2(WIN);
  localparam int DIV_MAX = (DIV_FAST > DIV_SLOW) ? DIV_FAST : DIV_SLOW;
  localparam int PS_W    = (DIV_MAX > 2) ? $clog2(DIV_MAX) : 1;
  localparam logic [CNT_W-1:0] NOMINAL = CNT_W'(WIN);
  localparam logic [CNT_W-1:0] TOL_V   = CNT_W'(TOL);
  localparam logic [WT_W-1:0]  WIN_END = WT_W'(WIN - 1);

  // ---------------- recovered-clock domain ----------------
  logic [PS_W-1:0]  preCnt;
  logic [PS_W-1:0]  divLast;
  logic             preWrap;
  logic [CNT_W-1:0] edgeCnt;
  logic [CNT_W-1:0] holdCnt;
  logic             reqTgl, reqRec, reqSeen, reqEdge;
  logic             ackTgl, ackRef, ackSeen, ackEdge;

  assign divLast = rateFast ? PS_W'(DIV_FAST - 1) : PS_W'(DIV_SLOW - 1);
  assign preWrap = (preCnt >= divLast);

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else       preCnt <= preWrap ? '0 : preCnt + 1'b1;
  end

  cdr_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_reqSync (
    .clk(recClk), .rstN(rstN), .d(reqTgl), .q(reqRec)
  );

  assign reqEdge = reqRec ^ reqSeen;

  always_ff @(posedge recClk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
      holdCnt <= '0;
      ackTgl  <= 1'b0;
      reqSeen <= 1'b0;
    end else begin
      reqSeen <= reqRec;
      if (reqEdge) begin
        holdCnt <= edgeCnt;
        edgeCnt <= {{(CNT_W-1){1'b0}}, preWrap};
        ackTgl  <= ~ackTgl;
      end else if (preWrap && (edgeCnt != '1)) begin
        edgeCnt <= edgeCnt + 1'b1;
      end
    end
  end

  // ---------------- reference domain ----------------
  logic [WT_W-1:0]  winCnt;
  logic [CNT_W-1:0] cntErr;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      winCnt <= '0;
      reqTgl <= 1'b0;
    end else if (winCnt == WIN_END) begin
      winCnt <= '0;
      reqTgl <= ~reqTgl;
    end else begin
      winCnt <= winCnt + 1'b1;
    end
  end

  cdr_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_ackSync (
    .clk(refClk), .rstN(rstN), .d(ackTgl), .q(ackRef)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) ackSeen <= 1'b0;
    else       ackSeen <= ackRef;
  end

  assign ackEdge = ackRef ^ ackSeen;

  always_comb begin
    if (holdCnt >= NOMINAL) cntErr = holdCnt - NOMINAL;
    else                    cntErr = NOMINAL - holdCnt;
  end

  // loss of signal
  logic sdRef, fnRef, losReg;

  cdr_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sdSync (
    .clk(refClk), .rstN(rstN), .d(sigDetIn), .q(sdRef)
  );
  cdr_sync_bit #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_fnSync (
    .clk(refClk), .rstN(rstN), .d(forceRefN), .q(fnRef)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) losReg <= 1'b1;
    else       losReg <= ~sdRef | ~fnRef;
  end

  assign stat.winDone = ackEdge;
  assign stat.winPass = (cntErr <= TOL_V);
  assign stat.los     = losReg;

  assign rxDataOut = rxDataIn & ~ctl.muteData;
endmodule

// File: rtl/cdr_sup_control.sv
`timescale 1ns/1ps
module cdr_sup_control
  import cdr_sup_pkg::*;
#(
  parameter int LOCK_PASSES = 2
) (
  input  logic       refClk,
  input  logic       rstN,
  input  meterStat_t stat,
  output ctlStrobe_t ctl,
  output logic       lockOut,
  output logic       trackSel
);
  localparam int PC_W = (LOCK_PASSES > 1) ? $clog2(LOCK_PASSES + 1) : 1;
  localparam logic [PC_W-1:0] PASS_LAST = PC_W'(LOCK_PASSES - 1);

  supState_t       state;
  logic [PC_W-1:0] passCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_REF;
      passCnt <= '0;
    end else if (stat.los) begin
      state   <= ST_REF;
      passCnt <= '0;
    end else if (stat.winDone) begin
      if (!stat.winPass) begin
        state   <= ST_REF;
        passCnt <= '0;
      end else if (state == ST_REF) begin
        if (passCnt == PASS_LAST) begin
          state   <= ST_DATA;
          passCnt <= '0;
        end else begin
          passCnt <= passCnt + 1'b1;
        end
      end
    end
  end

  assign lockOut      = (state == ST_DATA);
  assign trackSel     = (state == ST_DATA);
  assign ctl.muteData = stat.los;
endmodule

// File: rtl/cdr_lock_supervisor.sv
`timescale 1ns/1ps
module cdr_lock_supervisor
  import cdr_sup_pkg::*;
#(
  parameter int WIN         = 65536,
  parameter int TOL         = 32,
  parameter int DIV_FAST    = 32,
  parameter int DIV_SLOW    = 8,
  parameter int LOCK_PASSES = 2
) (
  input  logic refClk,
  input  logic recClk,
  input  logic rstN,
  input  logic rateFast,
  input  logic sigDetIn,
  input  logic forceRefN,
  input  logic rxDataIn,
  output logic rxDataOut,
  output logic lockOut,
  output logic trackSel,
  output logic losOut
);
  meterStat_t stat;
  ctlStrobe_t ctl;

  cdr_sup_datapath #(
    .WIN(WIN), .TOL(TOL), .DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .SYNC_STAGES(2)
  ) u_datapath (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .rateFast(rateFast),
    .sigDetIn(sigDetIn), .forceRefN(forceRefN), .rxDataIn(rxDataIn),
    .ctl(ctl), .stat(stat), .rxDataOut(rxDataOut)
  );

  cdr_sup_control #(.LOCK_PASSES(LOCK_PASSES)) u_control (
    .refClk(refClk), .rstN(rstN), .stat(stat), .ctl(ctl),
    .lockOut(lockOut), .trackSel(trackSel)
  );

  assign losOut = stat.los;
endmodule

// File: rtl/cdr_lock_supervisor_chk.sv
`timescale 1ns/1ps
module cdr_lock_supervisor_chk (
  input logic refClk,
  input logic rstN,
  input logic sigDetIn,
  input logic forceRefN,
  input logic rxDataOut,
  input logic losOut,
  input logic lockOut,
  input logic trackSel,
  input logic winDone,
  input logic winPass
);
  AST_LOS_FROM_SIGDET: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(sigDetIn, 3) |-> losOut); // R2

  AST_LOS_FROM_FORCE: assert property (@(posedge refClk) disable iff (!rstN)
    !$past(forceRefN, 3) |-> losOut); // R2

  AST_MUTE_ZERO: assert property (@(posedge refClk) disable iff (!rstN)
    losOut |-> !rxDataOut); // R3

  AST_LOCK_CLEAN_RISE: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockOut) |-> !$past(losOut)); // R6

  AST_FAIL_DROPS_LOCK: assert property (@(posedge refClk) disable iff (!rstN)
    (winDone && !winPass) |=> (!lockOut && !trackSel)); // R7

  AST_LOS_DROPS_LOCK: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(losOut) |=> !lockOut); // R8
endmodule

bind cdr_lock_supervisor cdr_lock_supervisor_chk u_chk (
  .refClk(refClk), .rstN(rstN), .sigDetIn(sigDetIn), .forceRefN(forceRefN),
  .rxDataOut(rxDataOut), .losOut(losOut), .lockOut(lockOut), .trackSel(trackSel),
  .winDone(stat.winDone), .winPass(stat.winPass)
);

// File: tb/cdr_lock_supervisor_bench.sv
`timescale 1ns/1ps
module cdr_lock_supervisor_bench;
  logic refClk = 1'b0;
  logic recClk = 1'b0;
  logic rstN = 1'b0;
  logic rateFast = 1'b1;
  logic sigDetIn = 1'b1;
  logic forceRefN = 1'b1;
  logic rxDataIn = 1'b0;
  logic rxDataOut, lockOut, trackSel, losOut;
  real  recHalf = 1.25;
  int   nChk = 0;
  int   nFail = 0;

  // shortened window: 256 ref cycles, tolerance 4, prescalers 4 / 2
  cdr_lock_supervisor #(
    .WIN(256), .TOL(4), .DIV_FAST(4), .DIV_SLOW(2), .LOCK_PASSES(2)
  ) u_cdr_lock_supervisor (
    .refClk(refClk), .recClk(recClk), .rstN(rstN), .rateFast(rateFast),
    .sigDetIn(sigDetIn), .forceRefN(forceRefN), .rxDataIn(rxDataIn),
    .rxDataOut(rxDataOut), .lockOut(lockOut), .trackSel(trackSel), .losOut(losOut)
  );

  always #5 refClk = ~refClk;
  always begin
    #(recHalf);
    recClk = ~recClk;
  end

  typedef struct packed {
    logic        fast;
    logic [15:0] perPs;
    logic        sd;
    logic        fn;
    logic        expLock;
    logic        expLos;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1, 16'd2500, 1'b1, 1'b1, 1'b1, 1'b0},  // R6 fast nominal
    '{1'b0, 16'd5000, 1'b1, 1'b1, 1'b1, 1'b0},  // R5 slow nominal
    '{1'b1, 16'd2525, 1'b1, 1'b1, 1'b1, 1'b0},  // R4 1% off, inside tolerance
    '{1'b1, 16'd2625, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 5% slow clock
    '{1'b0, 16'd4750, 1'b1, 1'b1, 1'b0, 1'b0},  // R4 5% fast clock
    '{1'b0, 16'd2500, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 fast clock, slow mode
    '{1'b1, 16'd5000, 1'b1, 1'b1, 1'b0, 1'b0},  // R5 slow clock, fast mode
    '{1'b1, 16'd2500, 1'b0, 1'b1, 1'b0, 1'b1},  // R2 signal detect low
    '{1'b1, 16'd2500, 1'b1, 1'b0, 1'b0, 1'b1}   // R2 force to reference
  };

  task automatic waitRef(input int n);
    repeat (n) @(posedge refClk);
    #1;
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic applyReset(input logic fast, input int perPs, input logic sd, input logic fn);
    rstN = 1'b0;
    rateFast = fast;
    sigDetIn = sd;
    forceRefN = fn;
    recHalf = perPs / 2000.0;
    waitRef(4);
    rstN = 1'b1;
  endtask

  initial begin
    waitRef(150000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    // R1 reset state
    rxDataIn = 1'b1;
    waitRef(3);
    chk("R1 lock in reset", lockOut, 1'b0);
    chk("R10 track in reset", trackSel, 1'b0);
    chk("R1 los in reset", losOut, 1'b1);
    chk("R1 data in reset", rxDataOut, 1'b0);
    rxDataIn = 1'b0;

    for (int i = 0; i < 9; i++) begin
      applyReset(VECS[i].fast, int'(VECS[i].perPs), VECS[i].sd, VECS[i].fn);
      if (i == 0) begin
        chk("R1 lock after release", lockOut, 1'b0);
        chk("R1 los after release", losOut, 1'b1);
      end
      waitRef(400);
      chk("R6 no lock after one window", lockOut, 1'b0);
      waitRef(700);
      chk($sformatf("R4/R5 vector %0d lock", i), lockOut, VECS[i].expLock);
      chk($sformatf("R10 vector %0d track", i), trackSel, VECS[i].expLock);
      chk($sformatf("R2 vector %0d los", i), losOut, VECS[i].expLos);
    end

    // R2 / R8: loss of signal latency while locked
    applyReset(1'b1, 2500, 1'b1, 1'b1);
    waitRef(1100);
    chk("R6 locked", lockOut, 1'b1);
    sigDetIn = 1'b0;
    waitRef(2);
    chk("R2 los not yet", losOut, 1'b0);
    waitRef(1);
    chk("R2 los after three edges", losOut, 1'b1);
    chk("R8 lock still held", lockOut, 1'b1);
    waitRef(1);
    chk("R8 lock dropped", lockOut, 1'b0);
    chk("R10 track dropped", trackSel, 1'b0);
    // R3 mute
    rxDataIn = 1'b1;
    #1;
    chk("R3 muted", rxDataOut, 1'b0);
    sigDetIn = 1'b1;
    waitRef(2);
    chk("R2 los still held", losOut, 1'b1);
    waitRef(1);
    chk("R2 los cleared", losOut, 1'b0);
    chk("R3 data passes 1", rxDataOut, 1'b1);
    rxDataIn = 1'b0;
    #1;
    chk("R3 data passes 0", rxDataOut, 1'b0);
    forceRefN = 1'b0;
    waitRef(3);
    chk("R2 force raises los", losOut, 1'b1);
    forceRefN = 1'b1;

    // R7 frequency drift while locked
    applyReset(1'b1, 2500, 1'b1, 1'b1);
    waitRef(1100);
    chk("R7 locked before drift", lockOut, 1'b1);
    recHalf = 2625 / 2000.0;
    waitRef(600);
    chk("R7 lock lost on drift", lockOut, 1'b0);
    chk("R7 track back to reference", trackSel, 1'b0);

    // R9 pass, fail, pass: run must restart
    applyReset(1'b1, 2500, 1'b1, 1'b1);
    waitRef(300);
    recHalf = 2625 / 2000.0;
    waitRef(220);
    recHalf = 1.25;
    waitRef(380);
    chk("R9 no lock after broken run", lockOut, 1'b0);
    waitRef(250);
    chk("R9 lock after two fresh passes", lockOut, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule